// File: doc/BRIEF.md
# Window-Select Barrel Shifter

This block is a purely combinational shifter for an N-bit datapath. Its core is a generic selector that looks at a row of 2N candidate bits and returns any N consecutive bits from that row. A one-hot column select chooses which run is returned. The row is built from two N-bit halves. The upper half occupies row positions 0 to N-1, and the lower half occupies positions N to 2N-1. Output bit i is row bit i+k when column k is selected.

A small front end turns a 2-bit mode and a binary shift amount into two things: the contents of the two halves and the window column. The core is the same for every mode. Only the fill and the column differ between logical right shift, logical left shift and rotate right. Any amount from 0 to N-1 resolves in one pass through the logic, with no clock and no stored state.

Top module: `window_shifter`

## Requirements
- R1: With mode 2'b00 (logical right shift) the output equals the data shifted toward bit 0 by the amount, and zeros enter at the most significant end.
- R2: With mode 2'b01 (logical left shift) the output equals the data shifted toward bit N-1 by the amount, and zeros enter at bit 0.
- R3: With mode 2'b10 (rotate right), output bit i equals data bit (i + amount) mod N.
- R4: Mode 2'b11 gives exactly the same result as mode 2'b10.
- R5: An amount of zero returns the data unchanged in every mode.
- R6: The output depends only on the present inputs. A change on any input appears at the output with no clock edge.
- R7: Exactly one window column is active for every amount and mode. As a result, data with a single set bit never produces more than one set output bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N | Word to shift or rotate |
| amt_i | input | log2(N) | Binary shift or rotate distance, 0 to N-1 |
| mode_i | input | 2 | 00 right shift, 01 left shift, 10/11 rotate right |
| data_o | output | N | Shifted or rotated word |

## Verification
Every amount in every mode is driven with several random words. A shift and a rotate differ only in what the vacated positions receive, and random words make that difference visible. Words of all ones show whether the zero fill is at the correct end. Walking single bits show that each output bit comes from exactly one row position, with no overlap between columns. A word that changes between clock edges is checked without an edge, which shows that the path holds no state.

// File: rtl/wshift_pkg.sv
package wshift_pkg;
  typedef enum logic [1:0] {
    MODE_SHR     = 2'b00,
    MODE_SHL     = 2'b01,
    MODE_ROR     = 2'b10,
    MODE_ROR_ALT = 2'b11
  } wshift_mode_e;
endpackage

// File: rtl/wshift_fill.sv
module wshift_fill
  import wshift_pkg::*;
#(
  parameter int N  = 16,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic [1:0]    mode_i,
  output logic [N-1:0]  upper_o,
  output logic [N-1:0]  lower_o,
  output logic [SW-1:0] col_o
);
  // Left shift reads the window at column N-amt, taken modulo N.
  // Amount zero folds onto column 0, so the upper half then carries the data.
  logic amt_zero;
  assign amt_zero = (amt_i == '0);

  always_comb begin
    upper_o = '0;
    lower_o = '0;
    col_o   = amt_i;
    case (wshift_mode_e'(mode_i))
      MODE_SHR: begin
        upper_o = data_i;
        lower_o = '0;
        col_o   = amt_i;
      end
      MODE_SHL: begin
        upper_o = amt_zero ? data_i : '0;
        lower_o = data_i;
        col_o   = SW'(0) - amt_i;
      end
      default: begin
        upper_o = data_i;
        lower_o = data_i;
        col_o   = amt_i;
      end
    endcase
  end
endmodule

// File: rtl/wshift_decode.sv
module wshift_decode #(
  parameter int N  = 16,
  parameter int SW = $clog2(N)
) (
  input  logic [SW-1:0] col_i,
  output logic [N-1:0]  sel_o
);
  for (genvar k = 0; k < N; k++) begin : g_col
    assign sel_o[k] = (col_i == SW'(k));
  end
endmodule

// File: rtl/wshift_window.sv
module wshift_window #(
  parameter int N = 16,
  localparam int ROW = 2 * N
) (
  input  logic [ROW-1:0] row_i,
  input  logic [N-1:0]   sel_i,
  output logic [N-1:0]   win_o
);
  logic [N-1:0] col_val [N];

  for (genvar k = 0; k < N; k++) begin : g_tap
    assign col_val[k] = sel_i[k] ? row_i[k +: N] : '0;
  end

  always_comb begin
    win_o = '0;
    for (int k = 0; k < N; k++) begin
      win_o = win_o | col_val[k];
    end
  end
endmodule

// File: rtl/window_shifter.sv
module window_shifter #(
  parameter int N = 16,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic [1:0]    mode_i,
  output logic [N-1:0]  data_o
);
  logic [N-1:0]   upper_half;
  logic [N-1:0]   lower_half;
  logic [SW-1:0]  win_col;
  logic [N-1:0]   win_sel;
  logic [2*N-1:0] cell_row;

  wshift_fill #(.N(N), .SW(SW)) u_fill (
    .data_i (data_i),
    .amt_i  (amt_i),
    .mode_i (mode_i),
    .upper_o(upper_half),
    .lower_o(lower_half),
    .col_o  (win_col)
  );

  wshift_decode #(.N(N), .SW(SW)) u_dec (
    .col_i(win_col),
    .sel_o(win_sel)
  );

  // Row positions 0..N-1 hold the upper half and N..2N-1 hold the lower half.
  assign cell_row = {lower_half, upper_half};

  wshift_window #(.N(N)) u_win (
    .row_i(cell_row),
    .sel_i(win_sel),
    .win_o(data_o)
  );
endmodule

// File: rtl/window_shifter_chk.sv
module window_shifter_chk #(
  parameter int N = 16,
  localparam int SW = $clog2(N)
) (
  input logic [N-1:0]  data_i,
  input logic [SW-1:0] amt_i,
  input logic [1:0]    mode_i,
  input logic [N-1:0]  data_o,
  input logic [N-1:0]  win_sel
);
  localparam logic [N-1:0] ONES = '1;

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot(win_sel)); // R7
    if (amt_i == '0) begin
      AST_ZERO_AMT_PASS: assert (data_o == data_i); // R5
    end
    if (mode_i == 2'b00) begin
      AST_SHR_TOP_CLEAR: assert ((data_o & ~(ONES >> amt_i)) == '0); // R1
    end
    if (mode_i == 2'b01) begin
      AST_SHL_LOW_CLEAR: assert ((data_o & ~(ONES << amt_i)) == '0); // R2
    end
    if (mode_i[1]) begin
      AST_ROT_KEEPS_WEIGHT: assert ($countones(data_o) == $countones(data_i)); // R3
    end
  end
endmodule

bind window_shifter window_shifter_chk #(.N(N)) u_chk (
  .data_i (data_i),
  .amt_i  (amt_i),
  .mode_i (mode_i),
  .data_o (data_o),
  .win_sel(win_sel)
);

// File: tb/tb_window_shifter.sv
`timescale 1ns/1ps
module tb_window_shifter;
  localparam int N  = 16;
  localparam int SW = $clog2(N);

  typedef struct {
    logic [N-1:0]  data;
    logic [SW-1:0] amt;
    logic [1:0]    mode;
    logic [N-1:0]  exp;
    string         tag;
  } item_t;

  logic clk;
  logic rst_n;
  logic [N-1:0]  data_i;
  logic [SW-1:0] amt_i;
  logic [1:0]    mode_i;
  logic [N-1:0]  data_o;

  item_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  window_shifter #(.N(N)) dut (
    .data_i(data_i),
    .amt_i (amt_i),
    .mode_i(mode_i),
    .data_o(data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [N-1:0] model(logic [N-1:0] d, logic [SW-1:0] s, logic [1:0] m);
    logic [2*N-1:0] dbl;
    dbl = {d, d} >> s;
    case (m)
      2'b00:   return d >> s;
      2'b01:   return d << s;
      default: return dbl[N-1:0];
    endcase
  endfunction

  function automatic string tag_for(logic [1:0] m, logic [SW-1:0] s);
    if (s == '0) return "R5";
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic drive(input logic [N-1:0] d, input logic [SW-1:0] s,
                       input logic [1:0] m, input string tag);
    item_t it;
    @(posedge clk);
    data_i <= d;
    amt_i  <= s;
    mode_i <= m;
    it.data = d; it.amt = s; it.mode = m; it.exp = model(d, s, m); it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares at the falling edge, half a period after drive.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (data_o !== it.exp) begin
          fails++;
          $display("FAIL %s mode=%b amt=%0d data=%h got=%h exp=%h",
                   it.tag, it.mode, it.amt, it.data, data_o, it.exp);
        end
        if (it.tag == "R7") begin
          checks++;
          if ($countones(data_o) > 1) begin
            fails++;
            $display("FAIL R7 mode=%b amt=%0d data=%h got=%h exp=at most one bit",
                     it.mode, it.amt, it.data, data_o);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired got=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    data_i = '0;
    amt_i  = '0;
    mode_i = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give an all-zero output (R5).
    @(negedge clk);
    checks++;
    if (data_o !== '0) begin
      fails++;
      $display("FAIL R5 idle got=%h exp=%h", data_o, {N{1'b0}});
    end

    // Every amount in every mode with random words (R1 R2 R3 R4 R5).
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < N; s++) begin
        for (int r = 0; r < 4; r++) begin
          drive(N'($urandom), SW'(s), 2'(m), tag_for(2'(m), SW'(s)));
        end
        drive('1, SW'(s), 2'(m), tag_for(2'(m), SW'(s)));
      end
    end

    // Walking single bits: no two columns may overlap (R7).
    for (int b = 0; b < N; b++) begin
      for (int s = 0; s < N; s += 5) begin
        for (int m = 0; m < 4; m++) begin
          drive(N'(1) << b, SW'(s), 2'(m), "R7");
        end
      end
    end

    // Rotate alias: mode 11 must agree with mode 10 on the same word (R4).
    for (int s = 1; s < N; s++) begin
      drive(16'hA5C3, SW'(s), 2'b11, "R4");
    end

    @(posedge clk);
    @(posedge clk);

    // No state: input changes between edges settle at once (R6).
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      logic [N-1:0] d;
      d = N'($urandom);
      data_i = d;
      amt_i  = SW'(k + 3);
      mode_i = 2'b10;
      #0.5;
      checks++;
      if (data_o !== model(d, SW'(k + 3), 2'b10)) begin
        fails++;
        $display("FAIL R6 amt=%0d data=%h got=%h exp=%h",
                 k + 3, d, data_o, model(d, SW'(k + 3), 2'b10));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule